// File: doc/BRIEF.md
# Dual-Byte Parallel-to-Serial Transmit Front End

This block takes a 20-bit word from a host and sends it out as a serial stream, one bit for each pulse of a bit-rate enable. The word is made of two 10-bit pre-encoded bytes. The lower byte goes out first, and within each byte the lowest-numbered bit leads. The whole block runs on one clock, `clk`. The bit-rate clock multiplier is outside the block, so the bit rate is given by `bit_en`.

The block keeps a bit counter that wraps once per word. From it the block derives the host byte-clock phase, `byte_clk`. In fast mode the byte clock lasts 20 bits. In slow mode it lasts 10 bits, so the host provides a fresh word only on every second byte clock. Two sampling strobes tell the host when each byte is taken:
- In the normal capture mode, both bytes are taken at the start of a word.
- In the split (ping-pong) capture mode, the upper byte is taken half a byte-clock later than the lower byte.

The captured word moves into the shift register on the last bit of the current word and is sent during the following word. The two mode inputs are sampled only at that same word boundary.

Top module: `pair_serializer`

## Requirements
- R1: `din[9:0]` is byte 0 and `din[19:10]` is byte 1.
- R2: `sdo` shows bit 0 of a word first and bit 19 last, one bit per `bit_en` pulse. Between pulses it holds its value.
- R3: With `pp_sel` latched low, both bytes are sampled only on a `bit_en` cycle at word position 0. `word_take` and `hi_take` both pulse in exactly that cycle.
- R4: With `pp_sel` latched high, byte 0 is still sampled at position 0 (`word_take`). Byte 1 is sampled half a byte-clock later (`hi_take`): at position 10 when `spd_sel` is latched high, and at position 5 when it is latched low. Byte 1 data at any other position is ignored.
- R5: `byte_clk` has a period of 20 word positions when `spd_sel` is latched high and 10 when it is latched low. It is high during the first half of each period. `word_take` fires only at position 0, so in slow mode a word is taken on every second byte clock.
- R6: The position counter wraps from 19 to 0. The word captured during one word period is sent in full during the next one, with bit 0 directly after the previous bit 19.
- R7: Changes on `pp_sel` and `spd_sel` take effect only at the wrap from position 19 to 0.
- R8: A synchronous active-high `rst` clears the counter, the captured bytes, the shift register and both latched modes. `sdo` is low while `rst` is high, and the first word sent after reset is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_en | input | 1 | One pulse per serial bit time |
| pp_sel | input | 1 | Split capture mode request (1 = byte 1 taken half a byte-clock late) |
| spd_sel | input | 1 | Speed request (1 = 20 bits per byte clock, 0 = 10) |
| din | input | 20 | Host word: byte 1 in [19:10], byte 0 in [9:0] |
| word_take | output | 1 | Byte 0 (and in normal mode byte 1) is sampled this cycle |
| hi_take | output | 1 | Byte 1 is sampled this cycle |
| byte_clk | output | 1 | Derived host byte-clock phase |
| sdo | output | 1 | Serial data out |

## Verification
A wrong counter position shows up at the ports within one bit time: `word_take`, `hi_take` and `byte_clk` all decode that position, so their pulses land at the wrong place. A capture register that was loaded at the wrong moment first becomes visible one word later, as wrong bits in `sdo`. The bench guards against this by presenting inverted decoy data at every position except the intended sampling point. A mode bit latched too early changes the strobe positions or the `byte_clk` phase while the current word is still running, so the fault appears in the same word.

// File: rtl/psr_pkg.sv
package psr_pkg;

  typedef struct packed {
    logic pp;
    logic fast;
  } cfg_t;

  // word positions per byte-clock period
  function automatic int byte_period(int byte_w, logic fast);
    return fast ? 2 * byte_w : byte_w;
  endfunction

  // position of the falling byte-clock edge inside a period
  function automatic int half_pos(int byte_w, logic fast);
    return byte_period(byte_w, fast) / 2;
  endfunction

  function automatic logic bclk_level(int byte_w, logic fast, int pos);
    return (pos % byte_period(byte_w, fast)) < half_pos(byte_w, fast);
  endfunction

endpackage

// File: rtl/psr_counter.sv
module psr_counter
  import psr_pkg::*;
#(
  parameter int WORD_W = 20,
  parameter int CW     = $clog2(WORD_W)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bit_en,
  input  logic          pp_in,
  input  logic          fast_in,
  output logic [CW-1:0] cnt,
  output logic          at_last,
  output cfg_t          cfg
);
  localparam logic [CW-1:0] LAST = CW'(WORD_W - 1);

  assign at_last = (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      cfg <= '0;
    end else if (bit_en) begin
      if (at_last) begin
        cnt      <= '0;
        cfg.pp   <= pp_in;
        cfg.fast <= fast_in;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/psr_capture.sv
module psr_capture #(
  parameter int BYTE_W = 10,
  parameter int NB     = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NB*BYTE_W-1:0] din,
  input  logic [NB-1:0]        take,
  output logic [NB*BYTE_W-1:0] word
);
  logic [BYTE_W-1:0] lane_q [NB];

  for (genvar g = 0; g < NB; g++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst)          lane_q[g] <= '0;
      else if (take[g]) lane_q[g] <= din[g*BYTE_W +: BYTE_W];
    end
    assign word[g*BYTE_W +: BYTE_W] = lane_q[g];
  end
endmodule

// File: rtl/psr_shifter.sv
module psr_shifter #(
  parameter int WORD_W = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_en,
  input  logic              load,
  input  logic [WORD_W-1:0] word,
  output logic              bit0,
  output logic              bit1
);
  logic [WORD_W-1:0] sh;

  always_ff @(posedge clk) begin
    if (rst)         sh <= '0;
    else if (bit_en) sh <= load ? word : {1'b0, sh[WORD_W-1:1]};
  end

  assign bit0 = sh[0];
  assign bit1 = sh[1];
endmodule

// File: rtl/pair_serializer.sv
module pair_serializer
  import psr_pkg::*;
#(
  parameter int BYTE_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_en,
  input  logic              pp_sel,
  input  logic              spd_sel,
  input  logic [2*BYTE_W-1:0] din,
  output logic              word_take,
  output logic              hi_take,
  output logic              byte_clk,
  output logic              sdo
);
  localparam int WORD_W = 2 * BYTE_W;
  localparam int CW     = $clog2(WORD_W);

  logic [CW-1:0]     cnt;
  logic              at_last;
  cfg_t              cfg;
  logic              cfg_pp;
  logic              cfg_fast;
  logic              load_ev;
  logic              hi_hit;
  logic [WORD_W-1:0] cap_word;
  logic              cap_lsb;
  logic              sh_bit0;
  logic              sh_bit1;

  psr_counter #(.WORD_W(WORD_W), .CW(CW)) u_cnt (
    .clk(clk), .rst(rst), .bit_en(bit_en),
    .pp_in(pp_sel), .fast_in(spd_sel),
    .cnt(cnt), .at_last(at_last), .cfg(cfg)
  );

  assign cfg_pp   = cfg.pp;
  assign cfg_fast = cfg.fast;
  assign load_ev  = bit_en & at_last;
  assign hi_hit   = (int'(cnt) == half_pos(BYTE_W, cfg_fast));

  assign word_take = bit_en & ~rst & (cnt == '0);
  assign hi_take   = cfg_pp ? (bit_en & ~rst & hi_hit) : word_take;
  assign byte_clk  = bclk_level(BYTE_W, cfg_fast, int'(cnt));

  psr_capture #(.BYTE_W(BYTE_W), .NB(2)) u_cap (
    .clk(clk), .rst(rst), .din(din),
    .take({hi_take, word_take}), .word(cap_word)
  );

  assign cap_lsb = cap_word[0];

  psr_shifter #(.WORD_W(WORD_W)) u_sh (
    .clk(clk), .rst(rst), .bit_en(bit_en), .load(at_last),
    .word(cap_word), .bit0(sh_bit0), .bit1(sh_bit1)
  );

  assign sdo = rst ? 1'b0 : sh_bit0;
endmodule

// File: rtl/psr_checker.sv
module psr_checker #(
  parameter int CW = 5
) (
  input logic          clk,
  input logic          rst,
  input logic          bit_en,
  input logic          load_ev,
  input logic [CW-1:0] cnt,
  input logic          cap_lsb,
  input logic          sh_bit1,
  input logic          sdo,
  input logic          cfg_pp,
  input logic          cfg_fast,
  input logic          word_take,
  input logic          hi_take
);
  assert_wrap_R6: assert property (@(posedge clk) disable iff (rst)
    load_ev |=> cnt == '0);

  assert_first_bit_R6: assert property (@(posedge clk) disable iff (rst)
    load_ev |=> sdo == $past(cap_lsb));

  assert_shift_R2: assert property (@(posedge clk) disable iff (rst)
    (bit_en && !load_ev) |=> sdo == $past(sh_bit1));

  assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !bit_en |=> $stable(sdo));

  assert_cfg_boundary_R7: assert property (@(posedge clk) disable iff (rst)
    !load_ev |=> ($stable(cfg_pp) && $stable(cfg_fast)));

  assert_split_R4: assert property (@(posedge clk) disable iff (rst)
    (cfg_pp && hi_take) |-> !word_take);

  assert_take_once_R5: assert property (@(posedge clk) disable iff (rst)
    word_take |=> !word_take);

  assert_reset_R8: assert property (@(posedge clk)
    rst |=> (cnt == '0 && !cfg_pp && !cfg_fast));
endmodule

bind pair_serializer psr_checker #(.CW(CW)) u_chk (
  .clk(clk), .rst(rst), .bit_en(bit_en), .load_ev(load_ev), .cnt(cnt),
  .cap_lsb(cap_lsb), .sh_bit1(sh_bit1), .sdo(sdo), .cfg_pp(cfg_pp),
  .cfg_fast(cfg_fast), .word_take(word_take), .hi_take(hi_take)
);

// File: tb/pair_serializer_bench.sv
`timescale 1ns/1ps
module pair_serializer_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bit_en = 1'b0;
  logic        pp_sel = 1'b0;
  logic        spd_sel = 1'b0;
  logic [19:0] din = '0;
  logic        word_take, hi_take, byte_clk, sdo;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  // bench model of the requirements
  int          pos_m = 0;
  int          widx = 0;
  logic [19:0] prev_m = '0;
  logic        cpp = 1'b0;
  logic        cfast = 1'b0;
  logic        want_rst = 1'b1;
  logic        want_pp = 1'b0;
  logic        want_fast = 1'b0;

  always #5 clk = ~clk;

  pair_serializer u_pair_serializer (
    .clk(clk), .rst(rst), .bit_en(bit_en), .pp_sel(pp_sel), .spd_sel(spd_sel),
    .din(din), .word_take(word_take), .hi_take(hi_take),
    .byte_clk(byte_clk), .sdo(sdo)
  );

  task automatic chk(input string rq, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s pos=%0d act=%0b exp=%0b", rq, pos_m, act, exp);
    end
  endtask

  function automatic logic [19:0] pat(int w);
    logic [31:0] h;
    h = (32'(w) * 32'h9E3779B1) ^ 32'h0005A5A5;
    if (w % 5 == 1) return 20'h1 << (w % 20);
    return h[25:6];
  endfunction

  task automatic tick(input logic be);
    int          hp;
    int          hpos;
    logic [19:0] p;
    logic [9:0]  f0;
    logic [9:0]  f1;
    @(negedge clk);
    hp   = cfast ? 10 : 5;
    hpos = cpp ? hp : 0;
    p    = pat(widx);
    // R1: byte 0 in [9:0], byte 1 in [19:10]; inverted decoys off the sample point
    f0 = (pos_m == 0)    ? p[9:0]   : ~p[9:0];
    f1 = (pos_m == hpos) ? p[19:10] : ~p[19:10];
    din     = {f1, f0};
    bit_en  = be;
    rst     = want_rst;
    pp_sel  = want_pp;
    spd_sel = want_fast;
    #1;
    if (rst) begin
      chk("R8 sdo low in reset", sdo, 1'b0);
    end else begin
      chk((pos_m == 0) ? "R6 bit after boundary" : "R2 serial bit", sdo, prev_m[pos_m]);
      chk("R1/R3 word_take", word_take, be && pos_m == 0);
      chk("R4 R7 hi_take", hi_take, be && pos_m == hpos);
      chk("R5 R7 byte_clk", byte_clk, (pos_m % (2 * hp)) < hp);
    end
    @(posedge clk);
    if (rst) begin
      pos_m = 0; widx = 0; prev_m = '0; cpp = 1'b0; cfast = 1'b0;
    end else if (be) begin
      if (pos_m == 19) begin
        prev_m = p; widx++; cpp = pp_sel; cfast = spd_sel; pos_m = 0;
      end else begin
        pos_m++;
      end
    end
  endtask

  initial begin
    want_rst = 1'b1;
    for (int i = 0; i < 3; i++) tick(1'b0);
    want_rst = 1'b0;
    // first word after reset is zeros (R8), then all four modes
    for (int c = 0; c < 4; c++) begin
      want_pp   = c[0];
      want_fast = c[1];
      for (int i = 0; i < 100; i++) tick(1'b1);
      for (int i = 0; i < 90; i++) tick(i % 3 != 0);
    end
    // mode requests toggling mid-word (R7)
    for (int i = 0; i < 240; i++) begin
      want_pp   = ((i / 13) % 2) == 1;
      want_fast = ((i / 29) % 2) == 1;
      tick(1'b1);
    end
    // reset in the middle of a word (R8)
    for (int i = 0; i < 7; i++) tick(1'b1);
    want_rst = 1'b1;
    for (int i = 0; i < 2; i++) tick(1'b1);
    want_rst  = 1'b0;
    want_pp   = 1'b1;
    want_fast = 1'b0;
    for (int i = 0; i < 80; i++) tick(1'b1);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1000000;
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule